// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the register-side half of a UART. A host reaches it over a simple 32-bit bus with one word address, a read strobe, a write strobe and write data. Read data is combinational from the current state. Any side effect of a read, such as popping a character, takes place on the clock edge that closes the read cycle. Characters from the receive path arrive on a byte stream with a valid/ready handshake. Each character carries four error bits. A separate break strobe inserts a break marker entry. Bytes the host writes to the data word leave on a one-cycle transmit strobe.

Received entries are 12 bits wide: the character in bits 7:0 and the error bits in bits 11:8. They are held in a circular queue that is either 16 deep or a single slot, depending on a bit of the line settings word. Popping an entry copies its error bits into a separate status word. Two raw interrupt sources, receive and transmit, are masked and ORed onto a single level interrupt line. The divisor, control, level-select and DMA words are storage only.

Top module: `uart_regif`

## Requirements
- R1: After reset the flag word (address 6) reads 0x90, the level-select word (13) reads 0x12, the control word (12) reads 0x300, irq is low, tx_valid is low and rx_ready is high.
- R2: With bit 4 of the line word (address 11) set, the queue accepts entries while it holds fewer than 16. rx_ready is low at 16. Reading address 0 returns entries oldest first, as {err[3:0], data[7:0]} in bits 11:0.
- R3: With bit 4 of the line word clear, a character is accepted only when the queue is empty, and rx_ready stays low while one entry is held.
- R4: A line-word write that changes bit 4 empties the queue and restarts it from slot 0. A line-word write that leaves bit 4 unchanged keeps the stored entries.
- R5: In the flag word, bit 7 (transmit empty) always reads 1 and bit 5 (transmit full) always reads 0. Bit 4 (receive empty) clears on a push and sets when a pop empties the queue. Bit 6 (receive full) sets on a push that fills the queue, or on any push in single-slot mode, and clears on every data read. Writes to the flag word are ignored.
- R6: A data read while the queue is empty moves nothing, and later pushes and pops keep their order.
- R7: A data read loads the status word (address 1) with bits 11:8 of the entry at the head. Any write to address 1 clears it.
- R8: A break strobe pushes entry 0x400 and takes priority over the byte stream, so rx_ready is low while the break strobe is high.
- R9: Raw interrupt bit 4 (receive) sets when a push brings the count to 1 and clears when a pop brings it to 0. The mask is at address 14, raw status at 15 and masked status at 16. irq is high exactly when the masked status is nonzero.
- R10: A write to address 0 drives its low byte on tx_data with tx_valid high for the following cycle, and sets raw interrupt bit 5.
- R11: A write to address 16+1=17 clears the raw interrupt bits where the written data is 1.
- R12: Addresses 0x3F8 to 0x3FF return the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R13: The storage words keep only their low bits on readback: address 8 keeps 8 bits, 9 keeps 16, 10 keeps 6, 11 keeps 8, 12 keeps 16, 13 keeps 6 and 18 keeps 3. Unmapped addresses, and the write-only address 17, read as 0.
- R14: In 16-deep mode, a push and a pop in the same cycle return the head entry and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (10) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_valid | input | 1 | Received character valid |
| rx_data | input | 8 | Received character |
| rx_err | input | 4 | Error bits of the received character |
| rx_ready | output | 1 | Queue can take a character |
| rx_break | input | 1 | Break event strobe |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 16-entry queue, a receive trigger of 1 and a 10-bit word address. With these values, filling the queue to its exact limit takes only sixteen pushes, and the full flag, the dropped extra push and the wrap of the read pointer all appear in a short run. The trigger of 1 puts both edges of the receive interrupt, on the first push and on the last pop, within a few cycles of each other.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int DATA_W  = 8;
  localparam int ERR_W   = 4;
  localparam int ENTRY_W = DATA_W + ERR_W;
  localparam int IRQ_W   = 11;
  localparam int IRQ_RX  = 4;
  localparam int IRQ_TX  = 5;
  localparam int LCR_FIFO_BIT = 4;

  localparam logic [ENTRY_W-1:0] BREAK_ENTRY = 12'h400;

  localparam int OFF_DATA = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_FLAG = 6;
  localparam int OFF_MASK = 14;
  localparam int OFF_RAW  = 15;
  localparam int OFF_MIS  = 16;
  localparam int OFF_ICLR = 17;

  localparam int NCFG     = 7;
  localparam int CFG_IRDA = 0;
  localparam int CFG_IDIV = 1;
  localparam int CFG_FDIV = 2;
  localparam int CFG_LINE = 3;
  localparam int CFG_CTRL = 4;
  localparam int CFG_LVL  = 5;
  localparam int CFG_DMA  = 6;

  function automatic int cfg_addr(input int idx);
    case (idx)
      CFG_IRDA: return 8;
      CFG_IDIV: return 9;
      CFG_FDIV: return 10;
      CFG_LINE: return 11;
      CFG_CTRL: return 12;
      CFG_LVL:  return 13;
      default:  return 18;
    endcase
  endfunction

  function automatic logic [31:0] cfg_mask(input int idx);
    case (idx)
      CFG_IDIV, CFG_CTRL: return 32'h0000_FFFF;
      CFG_FDIV, CFG_LVL:  return 32'h0000_003F;
      CFG_DMA:            return 32'h0000_0007;
      default:            return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [31:0] cfg_rst(input int idx);
    case (idx)
      CFG_CTRL: return 32'h0000_0300;
      CFG_LVL:  return 32'h0000_0012;
      default:  return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_regif_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               flush,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               pop_req,
  output logic [ENTRY_W-1:0] head_entry,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   cnt_nxt,
  output logic               popped,
  output logic               accept
);

  logic [PTR_W-1:0]   rd_ptr_q, rd_ptr_d, base_ptr, wr_slot;
  logic [CNT_W-1:0]   base_cnt;
  logic [PTR_W:0]     slot_sum;
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_comb begin
    base_ptr = flush ? '0 : rd_ptr_q;
    base_cnt = flush ? '0 : cnt_q;
    popped   = pop_req && !flush && (cnt_q != '0);
    slot_sum = {1'b0, base_ptr} + (PTR_W+1)'(base_cnt);
    if (slot_sum >= (PTR_W+1)'(DEPTH)) begin
      slot_sum = slot_sum - (PTR_W+1)'(DEPTH);
    end
    wr_slot = slot_sum[PTR_W-1:0];
    if (popped) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end else begin
      rd_ptr_d = base_ptr;
    end
    cnt_nxt = base_cnt + CNT_W'(push) - CNT_W'(popped);
    accept  = fifo_en ? (cnt_q < CNT_W'(DEPTH)) : (cnt_q == '0);
  end

  assign head_entry = mem_q[rd_ptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wr_slot] <= push_entry;
    end
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);

  logic [IRQ_W-1:0] raw_d, mask_d;

  always_comb begin
    raw_d  = (raw_q & ~clr_vec) | set_vec;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(raw_q & mask_q);

endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_regif_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCFG-1:0]            we,
  input  logic [31:0]                wdata,
  output logic [NCFG-1:0][31:0]      cfg_q
);

  for (genvar i = 0; i < NCFG; i++) begin : g_reg
    logic [31:0] d, q;
    always_comb begin
      d = we[i] ? (wdata & cfg_mask(i)) : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= cfg_rst(i);
      end else begin
        q <= d;
      end
    end
    assign cfg_q[i] = q;
  end

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int AW      = 10,
  parameter int RX_TRIG = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic [3:0]    rx_err,
  output logic          rx_ready,
  input  logic          rx_break,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_DATA = AW'(OFF_DATA);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_FLAG = AW'(OFF_FLAG);
  localparam logic [AW-1:0] A_MASK = AW'(OFF_MASK);
  localparam logic [AW-1:0] A_RAW  = AW'(OFF_RAW);
  localparam logic [AW-1:0] A_MIS  = AW'(OFF_MIS);
  localparam logic [AW-1:0] A_ICLR = AW'(OFF_ICLR);

  // decode
  logic rd_data, wr_data, wr_stat, wr_mask, wr_iclr;
  logic [NCFG-1:0] cfg_we;
  logic [NCFG-1:0][31:0] cfg_q;

  assign rd_data = bus_rd && (bus_addr == A_DATA);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_mask = bus_wr && (bus_addr == A_MASK);
  assign wr_iclr = bus_wr && (bus_addr == A_ICLR);

  for (genvar i = 0; i < NCFG; i++) begin : g_dec
    assign cfg_we[i] = bus_wr && (bus_addr == AW'(cfg_addr(i)));
  end

  uart_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (bus_wdata),
    .cfg_q (cfg_q)
  );

  // receive queue
  logic               fifo_en, flush, push, popped, accept;
  logic [ENTRY_W-1:0] push_entry, head_entry;
  logic [CNT_W-1:0]   rx_cnt, cnt_nxt;

  assign fifo_en    = cfg_q[CFG_LINE][LCR_FIFO_BIT];
  assign flush      = cfg_we[CFG_LINE] &&
                      (bus_wdata[LCR_FIFO_BIT] != cfg_q[CFG_LINE][LCR_FIFO_BIT]);
  assign rx_ready   = accept && !rx_break;
  assign push       = accept && (rx_break || rx_valid);
  assign push_entry = rx_break ? BREAK_ENTRY : {rx_err, rx_data};

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .flush      (flush),
    .push       (push),
    .push_entry (push_entry),
    .pop_req    (rd_data),
    .head_entry (head_entry),
    .cnt_q      (rx_cnt),
    .cnt_nxt    (cnt_nxt),
    .popped     (popped),
    .accept     (accept)
  );

  // interrupts
  logic [IRQ_W-1:0] irq_set, irq_clr, raw_q, mask_q;

  always_comb begin
    irq_set         = '0;
    irq_set[IRQ_RX] = push && (cnt_nxt == CNT_W'(RX_TRIG));
    irq_set[IRQ_TX] = wr_data;
    irq_clr         = wr_iclr ? bus_wdata[IRQ_W-1:0] : '0;
    if (popped && (cnt_nxt == CNT_W'(RX_TRIG - 1))) begin
      irq_clr[IRQ_RX] = 1'b1;
    end
  end

  uart_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (irq_set),
    .clr_vec    (irq_clr),
    .mask_we    (wr_mask),
    .mask_wdata (bus_wdata[IRQ_W-1:0]),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .irq        (irq)
  );

  // flags, receive status, transmit strobe
  logic             rx_empty_q, rx_empty_d, rx_full_q, rx_full_d;
  logic [ERR_W-1:0] stat_q, stat_d;
  logic             tx_valid_d;
  logic [7:0]       tx_data_d;

  always_comb begin
    rx_empty_d = rx_empty_q;
    rx_full_d  = rx_full_q;
    if (rd_data) begin
      rx_full_d = 1'b0;
      if (cnt_nxt == '0) rx_empty_d = 1'b1;
    end
    if (flush) begin
      rx_empty_d = 1'b1;
      rx_full_d  = 1'b0;
    end
    if (push) begin
      rx_empty_d = 1'b0;
      if (!fifo_en || (cnt_nxt == CNT_W'(DEPTH))) rx_full_d = 1'b1;
    end
    stat_d = stat_q;
    if (rd_data) begin
      stat_d = head_entry[ENTRY_W-1:DATA_W];
    end else if (wr_stat) begin
      stat_d = '0;
    end
    tx_valid_d = wr_data;
    tx_data_d  = wr_data ? bus_wdata[7:0] : tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      stat_q     <= '0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
    end else begin
      rx_empty_q <= rx_empty_d;
      rx_full_q  <= rx_full_d;
      stat_q     <= stat_d;
      tx_valid   <= tx_valid_d;
      tx_data    <= tx_data_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW-1:3] == '1) begin
      bus_rdata = {24'h0, id_byte(bus_addr[2:0])};
    end else begin
      case (bus_addr)
        A_DATA: bus_rdata = {{(32-ENTRY_W){1'b0}}, head_entry};
        A_STAT: bus_rdata = {{(32-ERR_W){1'b0}}, stat_q};
        A_FLAG: bus_rdata = {24'h0, 1'b1, rx_full_q, 1'b0, rx_empty_q, 4'h0};
        A_MASK: bus_rdata = {{(32-IRQ_W){1'b0}}, mask_q};
        A_RAW:  bus_rdata = {{(32-IRQ_W){1'b0}}, raw_q};
        A_MIS:  bus_rdata = {{(32-IRQ_W){1'b0}}, raw_q & mask_q};
        default: begin
          for (int i = 0; i < NCFG; i++) begin
            if (bus_addr == AW'(cfg_addr(i))) bus_rdata = cfg_q[i];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 10,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_break,
  input logic             tx_valid,
  input logic             fifo_en,
  input logic [CNT_W-1:0] rx_cnt
);

  p_accept_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |-> (rx_cnt < CNT_W'(DEPTH)));

  p_single_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_cnt != '0) |-> !rx_ready);

  p_flag_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(6)) |-> (bus_rdata[7] && !bus_rdata[5]));

  p_break_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |-> !rx_ready);

  p_tx_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> tx_valid);

  p_tx_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && bus_addr == '0));

  p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(2)) |-> (bus_rdata == '0));

endmodule

bind uart_regif uart_regif_chk #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_break  (rx_break),
  .tx_valid  (tx_valid),
  .fifo_en   (fifo_en),
  .rx_cnt    (rx_cnt)
);

// File: tb/tb_uart_regif.sv
module tb_uart_regif;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk, rst_n;
  logic          bus_rd, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          rx_valid, rx_ready, rx_break, tx_valid, irq;
  logic [7:0]    rx_data, tx_data;
  logic [3:0]    rx_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [11:0] exp_rx [$];
  logic [7:0]  exp_tx [$];

  uart_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .rx_ready(rx_ready), .rx_break(rx_break), .tx_valid(tx_valid),
    .tx_data(tx_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    if (a == 0) exp_tx.push_back(d[7:0]);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_check(string req, int a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // driver: offers a character, records it when the block takes it
  task automatic rx_send(logic [7:0] d, logic [3:0] e, output bit taken);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    #1 taken = rx_ready;
    if (taken) exp_rx.push_back({e, d});
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // monitor side of the scoreboard for received entries
  task automatic rx_pop_check(string req);
    logic [31:0] v;
    logic [11:0] e;
    rd(0, v);
    if (exp_rx.size() == 0) begin
      check(req, 32'hDEAD, 32'h0);
    end else begin
      e = exp_rx.pop_front();
      check(req, v, {20'h0, e});
      rd_check({req, " status R7"}, 1, {28'h0, e[11:8]});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_tx.size() == 0) check("R10 unexpected tx", {24'h0, tx_data}, 32'h0);
      else check("R10 tx byte", {24'h0, tx_data}, {24'h0, exp_tx.pop_front()});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    bit tk;
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 0; rx_data = '0; rx_err = '0; rx_break = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    #1;
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    rd_check("R1 flags", 6, 32'h90);
    rd_check("R1 level word", 13, 32'h12);
    rd_check("R1 control word", 12, 32'h300);

    // R13 storage widths, unmapped
    wr(8, 32'hFFFF_FFFF);  rd_check("R13 irda", 8, 32'hFF);
    wr(9, 32'hFFFF_FFFF);  rd_check("R13 idiv", 9, 32'hFFFF);
    wr(10, 32'hFFFF_FFFF); rd_check("R13 fdiv", 10, 32'h3F);
    wr(18, 32'hFFFF_FFFF); rd_check("R13 dma", 18, 32'h7);
    wr(12, 32'h1234_ABCD); rd_check("R13 ctrl", 12, 32'hABCD);
    wr(13, 32'h0000_0025); rd_check("R13 level", 13, 32'h25);
    rd_check("R13 unmapped", 2, 32'h0);
    rd_check("R13 iclr reads 0", 17, 32'h0);

    // R5 flag write ignored
    wr(6, 32'h0);
    rd_check("R5 flag write ignored", 6, 32'h90);

    // R12 identification
    for (int i = 0; i < 8; i++) begin
      logic [7:0] idv [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      rd_check("R12 id byte", 'h3F8 + i, {24'h0, idv[i]});
    end

    // R3 single slot, R9 receive interrupt
    wr(14, 32'h10);
    rx_send(8'hA5, 4'h0, tk);
    check("R3 first taken", {31'h0, tk}, 32'h1);
    #1 check("R3 ready low", {31'h0, rx_ready}, 32'h0);
    check("R9 irq high", {31'h0, irq}, 32'h1);
    rx_send(8'h5A, 4'h0, tk);
    check("R3 second refused", {31'h0, tk}, 32'h0);
    rd_check("R5 flags single full", 6, 32'hC0);
    rd_check("R9 masked", 16, 32'h10);
    rx_pop_check("R3 pop");
    rd_check("R5 flags after pop", 6, 32'h90);
    rd_check("R9 raw cleared", 15, 32'h0);
    #1 check("R9 irq low", {31'h0, irq}, 32'h0);

    // R10 transmit, R11 clear
    wr(0, 32'h0000_01C3);
    rd_check("R10 raw tx bit", 15, 32'h20);
    wr(14, 32'h20);
    #1 check("R10 irq from tx", {31'h0, irq}, 32'h1);
    wr(17, 32'h20);
    rd_check("R11 raw cleared", 15, 32'h0);
    #1 check("R11 irq low", {31'h0, irq}, 32'h0);
    wr(14, 32'h10);

    // R2 16-deep mode, fill and drain
    wr(11, 32'h10);
    for (int i = 0; i < 16; i++) begin
      rx_send(8'(8'h30 + i), 4'(i), tk);
      check("R2 accepted", {31'h0, tk}, 32'h1);
    end
    #1 check("R2 ready low when full", {31'h0, rx_ready}, 32'h0);
    rx_send(8'hEE, 4'h0, tk);
    check("R2 extra refused", {31'h0, tk}, 32'h0);
    rd_check("R5 flags full", 6, 32'hC0);
    rx_pop_check("R2 pop first");
    rd_check("R5 full clears on read", 6, 32'h80);
    rd_check("R9 raw held while nonempty", 15, 32'h10);
    for (int i = 0; i < 15; i++) rx_pop_check("R2 pop order");
    rd_check("R5 empty after drain", 6, 32'h90);
    rd_check("R9 raw cleared after drain", 15, 32'h0);

    // R4 unchanged bit keeps contents, toggle flushes
    for (int i = 0; i < 3; i++) rx_send(8'(8'h60 + i), 4'h1, tk);
    wr(11, 32'h70);
    rd_check("R13 line word", 11, 32'h70);
    rx_pop_check("R4 kept");
    wr(11, 32'h00);
    exp_rx.delete();
    rd_check("R4 flushed flags", 6, 32'h90);
    #1 check("R4 ready after flush", {31'h0, rx_ready}, 32'h1);
    rx_send(8'h99, 4'h2, tk);
    rx_pop_check("R4 after flush");

    // R8 break priority, R7 status clear
    wr(11, 32'h10);
    @(negedge clk);
    rx_break = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
    #1 check("R8 ready low on break", {31'h0, rx_ready}, 32'h0);
    exp_rx.push_back(12'h400);
    @(negedge clk);
    rx_break = 1'b0; rx_valid = 1'b0;
    rx_pop_check("R8 break entry");
    wr(1, 32'h0);
    rd_check("R7 status cleared", 1, 32'h0);

    // R14 simultaneous push and pop
    rx_send(8'h41, 4'h0, tk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h42; rx_err = 4'h3;
    bus_rd = 1'b1; bus_addr = '0;
    #1 v = bus_rdata;
    check("R14 ready", {31'h0, rx_ready}, 32'h1);
    exp_rx.push_back(12'h342);
    check("R14 head", v, {20'h0, exp_rx.pop_front()});
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0;
    rx_pop_check("R14 remaining");
    rd_check("R14 empty after", 6, 32'h90);

    // R6 read at empty
    rd(0, v);
    rd_check("R6 flags unchanged", 6, 32'h90);
    rd_check("R6 raw unchanged", 15, 32'h0);
    rx_send(8'hB7, 4'h5, tk);
    rx_send(8'hB8, 4'h6, tk);
    rx_pop_check("R6 order first");
    rx_pop_check("R6 order second");

    repeat (3) @(negedge clk);
    check("R10 tx queue drained", exp_tx.size(), 32'h0);
    finish_run();
  end

endmodule